// File: doc/BRIEF.md
# Two-Thread Core Idle-State Sequencer

This block decides which idle state a two-thread core is in and drives the handshakes that get the core into that state and back out. Each thread posts a requested idle level. The core level is the shallowest of the posted levels. The two shallow levels (C1, C1E) need no handshake. The core keeps servicing snoops and wakes only on an interrupt or on a monitored-address hit.

The two deep levels each have an ordered entry. For C3, the private caches are written back to the shared cache and then the core clocks are gated. For C6, the architectural state is saved to a local save memory and then the power rail is switched off. Leaving C6 runs in the reverse order: power comes back first, then the saved state is reloaded, then execution resumes.

A wake that arrives while an entry is still in progress abandons that entry and returns the core straight to running. The caches, the save memory and the regulator are represented here only by their request and done wires.

Top module: `core_idle_seq`

## Requirements
- R1: Idle levels use the 3-bit codes C0=0, C1=1, C1E=2, C3=3, C6=4, and a posted code of 5 to 7 is taken as C6. While no sequence is running, `core_state` shows the lowest code held by any thread, from the clock edge after the requests were accepted; a lowest code of C3 or C6 is shown as C0 until the park state is reached.
- R2: After reset `core_state` is 0, every `thr_run` bit is 1, and `busy`, `flush_req`, `clk_stop`, `save_req`, `pwr_off` and `restore_req` are all 0; a reset asserted while threads are idle also returns them to this state.
- R3: An interrupt on `irq[t]` sets only thread t back to C0, so only `thr_run[t]` rises and `core_state` becomes C0 at the next edge.
- R4: `mon_hit` wakes every idle thread whose accepted request had its `req_mwait` bit set, and has no effect on a thread whose request had that bit clear.
- R5: `snoop` never changes `core_state`, either in C1/C1E or while parked in C3.
- R6: When the lowest code is C3, `flush_req` rises one edge later. `flush_done` then drops `flush_req`, raises `clk_stop` and shows `core_state`=3. A wake while parked in C3 drops `clk_stop` at the next edge.
- R7: When the lowest code is C6, `save_req` rises one edge later. `save_done` then drops `save_req`, raises `pwr_off` and shows `core_state`=4.
- R8: A wake while parked in C6 drops `pwr_off`. `restore_req` then rises on the edge that samples `pwr_ok` and stays high until `restore_done`, after which the core runs with `busy` low.
- R9: A wake during the flush or the save abandons the entry: the next edge returns to running with `clk_stop`, `pwr_off` and `restore_req` all low, even if `flush_done` or `save_done` arrives in the same cycle.
- R10: `busy` is high during flush, save, power-up and restore, and at most one of the five handshake outputs is high at a time. `req_valid` is ignored while busy or parked.
- R11: `thr_run[t]` is 1 exactly when thread t holds C0, and any running thread forces `core_state` to C0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NTHR | Per-thread request strobe |
| req_state | input | 3*NTHR | Per-thread requested level, 3 bits per thread |
| req_mwait | input | NTHR | Request made through the monitor-wait path |
| irq | input | NTHR | Per-thread interrupt |
| mon_hit | input | 1 | Access to the monitored address |
| snoop | input | 1 | Snoop activity (no wake effect) |
| flush_done | input | 1 | Cache write-back finished |
| save_done | input | 1 | State save finished |
| pwr_ok | input | 1 | Core rail back up |
| restore_done | input | 1 | State reload finished |
| flush_req | output | 1 | Cache write-back request |
| clk_stop | output | 1 | Core clock gate enable |
| save_req | output | 1 | State save request |
| pwr_off | output | 1 | Power gate enable |
| restore_req | output | 1 | State reload request |
| busy | output | 1 | Entry or exit sequence in progress |
| core_state | output | 3 | Resolved core idle level |
| thr_run | output | NTHR | Per-thread running flag |

## Verification
On every cycle, the checker confirms the following: clocks gate only after a finished flush, power gates only after a finished save, and reload starts only once the rail is good. It also checks that the handshake outputs never overlap, that any running thread means a C0 core, and that a snoop cannot disturb C3. The bench scenarios show the rest: minimum resolution across many request pairs, which wake source counts for which entry type, per-thread wake selectivity, aborted flushes and saves, and requests being ignored while the sequencer is occupied.

// File: rtl/idle_pkg.sv
package idle_pkg;
   localparam int CSW = 3;

   typedef enum logic [CSW-1:0] {
      CS_C0  = 3'd0,
      CS_C1  = 3'd1,
      CS_C1E = 3'd2,
      CS_C3  = 3'd3,
      CS_C6  = 3'd4
   } cstate_e;

   typedef enum logic [2:0] {
      SQ_RUN, SQ_FLUSH, SQ_PARK3, SQ_SAVE, SQ_PARK6, SQ_PWRUP, SQ_RESTORE
   } seq_e;

   function automatic cstate_e clip_level(input logic [CSW-1:0] v);
      return (v > 3'd4) ? CS_C6 : cstate_e'(v);
   endfunction
endpackage

// File: rtl/idle_thread_slot.sv
module idle_thread_slot
   import idle_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            accept,
   input  logic            req_v,
   input  logic [CSW-1:0]  req_lvl,
   input  logic            req_mw,
   input  logic            irq,
   input  logic            mon_hit,
   output cstate_e         lvl,
   output logic            woke
);
   logic mw_q;

   assign woke = irq | (mon_hit & mw_q & (lvl != CS_C0));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lvl  <= CS_C0;
         mw_q <= 1'b0;
      end else if (woke) begin
         lvl  <= CS_C0;
         mw_q <= 1'b0;
      end else if (accept && req_v) begin
         lvl  <= clip_level(req_lvl);
         mw_q <= req_mw;
      end
   end
endmodule

// File: rtl/idle_min_resolve.sv
module idle_min_resolve
   import idle_pkg::*;
#(
   parameter int NTHR = 2
) (
   input  logic [NTHR*CSW-1:0] lvls,
   output cstate_e             lowest
);
   always_comb begin
      lowest = CS_C6;
      for (int t = 0; t < NTHR; t++) begin
         if (lvls[t*CSW +: CSW] < lowest) lowest = cstate_e'(lvls[t*CSW +: CSW]);
      end
   end
endmodule

// File: rtl/idle_seq_fsm.sv
module idle_seq_fsm
   import idle_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  cstate_e lowest,
   input  logic    wake,
   input  logic    flush_done,
   input  logic    save_done,
   input  logic    pwr_ok,
   input  logic    restore_done,
   output logic    accept,
   output logic    flush_req,
   output logic    clk_stop,
   output logic    save_req,
   output logic    pwr_off,
   output logic    restore_req,
   output logic    busy,
   output cstate_e core_state
);
   seq_e st, nxt;

   always_comb begin
      nxt = st;
      unique case (st)
         SQ_RUN: begin
            if (!wake && lowest == CS_C3) nxt = SQ_FLUSH;
            else if (!wake && lowest == CS_C6) nxt = SQ_SAVE;
         end
         SQ_FLUSH:   if (wake) nxt = SQ_RUN; else if (flush_done) nxt = SQ_PARK3;
         SQ_PARK3:   if (wake) nxt = SQ_RUN;
         SQ_SAVE:    if (wake) nxt = SQ_RUN; else if (save_done) nxt = SQ_PARK6;
         SQ_PARK6:   if (wake) nxt = SQ_PWRUP;
         SQ_PWRUP:   if (pwr_ok) nxt = SQ_RESTORE;
         SQ_RESTORE: if (restore_done) nxt = SQ_RUN;
         default:    nxt = SQ_RUN;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st <= SQ_RUN;
      else        st <= nxt;
   end

   assign accept      = (st == SQ_RUN);
   assign flush_req   = (st == SQ_FLUSH);
   assign clk_stop    = (st == SQ_PARK3);
   assign save_req    = (st == SQ_SAVE);
   assign pwr_off     = (st == SQ_PARK6);
   assign restore_req = (st == SQ_RESTORE);
   assign busy        = flush_req | save_req | restore_req | (st == SQ_PWRUP);

   always_comb begin
      unique case (st)
         SQ_RUN:   core_state = (lowest >= CS_C3) ? CS_C0 : lowest;
         SQ_PARK3: core_state = CS_C3;
         SQ_PARK6: core_state = CS_C6;
         default:  core_state = CS_C0;
      endcase
   end
endmodule

// File: rtl/core_idle_seq.sv
module core_idle_seq
   import idle_pkg::*;
#(
   parameter int NTHR = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NTHR-1:0]     req_valid,
   input  logic [NTHR*3-1:0]   req_state,
   input  logic [NTHR-1:0]     req_mwait,
   input  logic [NTHR-1:0]     irq,
   input  logic                mon_hit,
   input  logic                snoop,
   input  logic                flush_done,
   input  logic                save_done,
   input  logic                pwr_ok,
   input  logic                restore_done,
   output logic                flush_req,
   output logic                clk_stop,
   output logic                save_req,
   output logic                pwr_off,
   output logic                restore_req,
   output logic                busy,
   output logic [2:0]          core_state,
   output logic [NTHR-1:0]     thr_run
);
   localparam int LVW = NTHR * CSW;

   if (NTHR < 1) begin : g_bad_nthr
      $error("core_idle_seq: NTHR must be at least 1");
   end
   if (CSW != 3) begin : g_bad_csw
      $error("core_idle_seq: level code width must be 3");
   end

   logic [LVW-1:0]  lvls;
   logic [NTHR-1:0] woke;
   logic            accept;
   cstate_e         lowest;
   cstate_e         cs;
   logic            unused_snoop;

   assign unused_snoop = snoop;

   for (genvar t = 0; t < NTHR; t++) begin : g_thr
      cstate_e lvl_t;
      idle_thread_slot i_slot (
         .clk     (clk),
         .rst_n   (rst_n),
         .accept  (accept),
         .req_v   (req_valid[t]),
         .req_lvl (req_state[t*CSW +: CSW]),
         .req_mw  (req_mwait[t]),
         .irq     (irq[t]),
         .mon_hit (mon_hit),
         .lvl     (lvl_t),
         .woke    (woke[t])
      );
      assign lvls[t*CSW +: CSW] = lvl_t;
      assign thr_run[t]         = (lvl_t == CS_C0);
   end

   idle_min_resolve #(.NTHR(NTHR)) i_res (
      .lvls   (lvls),
      .lowest (lowest)
   );

   idle_seq_fsm i_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .lowest       (lowest),
      .wake         (|woke),
      .flush_done   (flush_done),
      .save_done    (save_done),
      .pwr_ok       (pwr_ok),
      .restore_done (restore_done),
      .accept       (accept),
      .flush_req    (flush_req),
      .clk_stop     (clk_stop),
      .save_req     (save_req),
      .pwr_off      (pwr_off),
      .restore_req  (restore_req),
      .busy         (busy),
      .core_state   (cs)
   );

   assign core_state = cs;
endmodule

// File: rtl/core_idle_seq_chk.sv
module core_idle_seq_chk #(
   parameter int NTHR = 2
) (
   input logic            clk,
   input logic            rst_n,
   input logic [NTHR-1:0] irq,
   input logic            mon_hit,
   input logic            snoop,
   input logic            flush_done,
   input logic            save_done,
   input logic            pwr_ok,
   input logic            flush_req,
   input logic            clk_stop,
   input logic            save_req,
   input logic            pwr_off,
   input logic            restore_req,
   input logic            busy,
   input logic [2:0]      core_state,
   input logic [NTHR-1:0] thr_run
);
   a_r6_stop_after_flush: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(clk_stop) |-> $past(flush_req && flush_done));

   a_r7_gate_after_save: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwr_off) |-> $past(save_req && save_done));

   a_r8_reload_after_rail: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(restore_req) |-> $past(pwr_ok && !pwr_off));

   a_r10_one_handshake: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({flush_req, clk_stop, save_req, pwr_off, restore_req}));

   a_r10_busy_covers_req: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_req || save_req || restore_req) |-> busy);

   a_r11_run_means_c0: assert property (@(posedge clk) disable iff (!rst_n)
      (|thr_run) |-> (core_state == 3'd0));

   a_r5_snoop_keeps_c3: assert property (@(posedge clk) disable iff (!rst_n)
      (core_state == 3'd3 && snoop && !(|irq) && !mon_hit) |=> (core_state == 3'd3));
endmodule

bind core_idle_seq core_idle_seq_chk #(.NTHR(NTHR)) i_chk (.*);

// File: tb/test_core_idle_seq.sv
module test_core_idle_seq;
   localparam int NTHR = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NTHR-1:0]   req_valid = '0;
   logic [NTHR*3-1:0] req_state = '0;
   logic [NTHR-1:0]   req_mwait = '0;
   logic [NTHR-1:0]   irq = '0;
   logic mon_hit = 0, snoop = 0, flush_done = 0, save_done = 0, pwr_ok = 0, restore_done = 0;
   logic flush_req, clk_stop, save_req, pwr_off, restore_req, busy;
   logic [2:0] core_state;
   logic [NTHR-1:0] thr_run;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   core_idle_seq #(.NTHR(NTHR)) i_core_idle_seq (.*);

   // {thread0 level, thread1 level, expected core level}
   localparam logic [8:0] VEC [7] = '{
      {3'd1, 3'd1, 3'd1}, {3'd2, 3'd3, 3'd2}, {3'd0, 3'd4, 3'd0},
      {3'd2, 3'd2, 3'd2}, {3'd1, 3'd2, 3'd1}, {3'd3, 3'd1, 3'd1},
      {3'd5, 3'd2, 3'd2}
   };

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic post(input logic [2:0] s0, input logic [2:0] s1, input logic [1:0] mw);
      req_valid = 2'b11;
      req_state = {s1, s0};
      req_mwait = mw;
      tick();
      req_valid = '0;
      req_mwait = '0;
   endtask

   task automatic wake_all();
      irq = 2'b11;
      tick();
      irq = '0;
   endtask

   task automatic hs(input logic [4:0] exp, input string tag);
      chk(tag, {flush_req, clk_stop, save_req, pwr_off, restore_req}, exp);
   endtask

   initial begin
      #1_000_000;
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      chk("R2 core", core_state, 0);
      chk("R2 run", thr_run, 2'b11);
      chk("R2 busy", busy, 0);
      hs(5'b0, "R2 handshakes");

      // R1 / R11 vector table
      foreach (VEC[i]) begin
         post(VEC[i][8:6], VEC[i][5:3], 2'b00);
         chk($sformatf("R1 vec%0d core", i), core_state, VEC[i][2:0]);
         chk($sformatf("R11 vec%0d run", i), thr_run,
             {VEC[i][5:3] == 3'd0, VEC[i][8:6] == 3'd0});
      end
      wake_all();

      // R5 snoop in C1
      post(3'd1, 3'd1, 2'b00);
      snoop = 1; tick(); snoop = 0;
      chk("R5 snoop C1", core_state, 1);

      // R3 single-thread interrupt
      irq = 2'b10; tick(); irq = '0;
      chk("R3 run", thr_run, 2'b10);
      chk("R3 core", core_state, 0);
      wake_all();

      // R4 monitor hit only for mwait-entered thread
      post(3'd1, 3'd2, 2'b01);
      mon_hit = 1; tick(); mon_hit = 0;
      chk("R4 hit mw", thr_run, 2'b01);
      mon_hit = 1; tick(); mon_hit = 0;
      chk("R4 hit ignored", thr_run, 2'b01);
      chk("R4 core", core_state, 0);
      wake_all();

      // R6 C3 entry, snoop, exit
      post(3'd3, 3'd3, 2'b00);
      chk("R1 deep shows C0", core_state, 0);
      tick();
      hs(5'b10000, "R6 flush_req");
      chk("R10 busy flush", busy, 1);
      flush_done = 1; tick(); flush_done = 0;
      hs(5'b01000, "R6 clk_stop");
      chk("R6 core C3", core_state, 3);
      snoop = 1; tick(); snoop = 0;
      chk("R5 snoop C3", core_state, 3);
      hs(5'b01000, "R5 still stopped");
      irq = 2'b01; tick(); irq = '0;
      hs(5'b00000, "R6 exit");
      chk("R6 run", thr_run, 2'b01);
      wake_all();

      // R9 abort flush with done in same cycle
      post(3'd3, 3'd4, 2'b00);
      tick();
      hs(5'b10000, "R9 flush start");
      irq = 2'b10; flush_done = 1; tick(); irq = '0; flush_done = 0;
      hs(5'b00000, "R9 flush abort");
      chk("R9 busy", busy, 0);
      tick();
      hs(5'b00000, "R9 stays running");
      wake_all();

      // R7 / R8 C6 entry and exit via monitor hit
      post(3'd4, 3'd4, 2'b11);
      tick();
      hs(5'b00100, "R7 save_req");
      save_done = 1; tick(); save_done = 0;
      hs(5'b00010, "R7 pwr_off");
      chk("R7 core C6", core_state, 4);
      mon_hit = 1; tick(); mon_hit = 0;
      hs(5'b00000, "R8 rail up wait");
      chk("R8 busy", busy, 1);
      chk("R4 mw wake C6", thr_run, 2'b11);
      tick();
      hs(5'b00000, "R8 wait pwr_ok");
      pwr_ok = 1; tick(); pwr_ok = 0;
      hs(5'b00001, "R8 restore_req");
      tick();
      hs(5'b00001, "R8 restore holds");
      restore_done = 1; tick(); restore_done = 0;
      hs(5'b00000, "R8 done");
      chk("R8 busy low", busy, 0);

      // R9 / R10 / R4 abort save, requests ignored while busy
      post(3'd4, 3'd4, 2'b00);
      tick();
      hs(5'b00100, "R9 save start");
      req_valid = 2'b10; req_state = {3'd0, 3'd0}; tick(); req_valid = '0;
      chk("R10 req ignored", thr_run, 2'b00);
      mon_hit = 1; tick(); mon_hit = 0;
      hs(5'b00100, "R4 non-mw hit ignored");
      irq = 2'b01; save_done = 1; tick(); irq = '0; save_done = 0;
      hs(5'b00000, "R9 save abort");
      tick();
      hs(5'b00000, "R9 no restore");
      chk("R9 run", thr_run, 2'b01);
      wake_all();

      // R2 reset while idle
      post(3'd2, 3'd1, 2'b00);
      rst_n = 0; tick(); rst_n = 1; tick();
      chk("R2 reset core", core_state, 0);
      chk("R2 reset run", thr_run, 2'b11);

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule